// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of a NAND flash device and runs one block erase for each accepted request. When the host raises `start_i` with a block number, the sequencer drives the command latch, address latch, write strobe and data bus itself. It sends the erase-setup command. It then sends the row address split over two bus cycles, with the page bits forced to zero so that only the block number is carried. Last it sends the erase-confirm command. After the confirm strobe it regards the flash as busy. Completion is found in one of two ways, chosen per request by `use_poll_i`. In the first, the sequencer watches the ready/busy line and then reads status once. In the second, it issues the read-status command straight away and keeps pulsing the read strobe until the ready bit comes back set. When the erase ends it reports pass or fail from the status byte. If the wait lasts too long it reports a timeout instead.

The state machine has these states:

- `ST_IDLE` waits for a request.
- `ST_SETUP` sends command 60h.
- `ST_ADDR` sends the two row bytes.
- `ST_CONF` sends command D0h.
- `ST_WAIT_RB` (ready/busy method) waits out a short guard window and then waits for the ready/busy line to go high.
- `ST_STAT_CMD` sends command 70h.
- `ST_STAT_RD` repeats read pulses until the ready bit is seen.

The transitions are:

- IDLE→SETUP on an accepted start.
- SETUP→ADDR when the strobe cycle ends.
- ADDR→ADDR after each row byte but the last.
- ADDR→CONF after the last row byte.
- CONF→WAIT_RB when the ready/busy method is selected.
- CONF→STAT_CMD when the polling method is selected.
- WAIT_RB→STAT_CMD when the guard has elapsed and the line is high.
- STAT_CMD→STAT_RD when the command strobe ends.
- STAT_RD→STAT_RD while the ready bit is clear.
- STAT_RD→IDLE on success.
- Any waiting state→IDLE on timeout.

Every bus cycle is timed by one shared strobe timer. The strobe stays low for a programmed number of clocks and then high for a programmed number of clocks. Each cycle latches on the rising edge of the strobe. Command latch, address latch and bus data are held steady for the whole cycle.

Top module: `nand_erase_seq`

## Requirements
- R1: An accepted erase produces write-strobe cycles in this order: command 60h with the command latch high, two address cycles with the address latch high, then command D0h with the command latch high. Each is latched on the rising edge of `nand_we_n_o`.
- R2: The first address byte is {block[1:0], 000000b}. The second is block[9:2]. The six page bits are always driven as zero.
- R3: Each write strobe stays low for max(`bus_low_cyc_i`,1) clocks. Inside the setup/address/confirm burst, consecutive strobes are max(`bus_high_cyc_i`,1)+1 clocks apart. The command latch and address latch are never high together.
- R4: With `use_poll_i`=0 the sequencer ignores `nand_rb_n_i` for 4 clocks after the confirm cycle. It then issues the read-status command only once `nand_rb_n_i` is high.
- R5: With `use_poll_i`=1 the sequencer issues exactly one 70h command right after D0h. It then pulses `nand_re_n_o` until a sampled status byte has bit 6 set.
- R6: From the confirm cycle until completion, the only command on the bus is 70h. `start_i` is ignored while `busy_o` is high, so no extra 60h appears and the latched block is unchanged.
- R7: `done_o` pulses for one clock when the sequencer returns to idle. `fail_o` then equals bit 0 of the first status byte that had bit 6 set, and holds until the next accepted start.
- R8: If more than `timeout_lim_i` clocks pass in the waiting states, the sequencer returns to idle and pulses `done_o` with `timeout_o`=1 and `fail_o`=0. Both strobes are left high.
- R9: A `start_i` that is high in the cycle `done_o` pulses is accepted and starts a new erase at once.
- R10: `nand_io_oe_o` is high during command and address cycles and low while `nand_re_n_o` is low. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Erase request, accepted in idle |
| blk_addr_i | input | 10 | Block number to erase |
| use_poll_i | input | 1 | 1: poll status bit 6; 0: wait on ready/busy line |
| bus_low_cyc_i | input | 4 | Strobe low width in clocks (0 treated as 1) |
| bus_high_cyc_i | input | 4 | Strobe high width in clocks (0 treated as 1) |
| timeout_lim_i | input | 16 | Clock limit for the busy wait |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | Bus data driven to flash |
| nand_io_oe_o | output | 1 | Bus output enable |
| nand_io_i | input | 8 | Bus data from flash |
| nand_rb_n_i | input | 1 | Ready/busy line, low while busy |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-clock completion pulse |
| fail_o | output | 1 | Erase failed (status bit 0) |
| timeout_o | output | 1 | Busy wait exceeded the limit |

## Verification
Two events can fall in one cycle: the completion pulse that ends one erase, and the acceptance of a new start request. The bench provokes this by holding `start_i` high through a whole erase. While that erase is busy it also changes `blk_addr_i`. It then judges two things: that the first erase's result is reported correctly in the cycle of the pulse, and that the following cycle already belongs to a second erase. That second erase must carry the new block in its address bytes. A start pulsed in the middle of a long busy wait is also applied; it must leave exactly one setup command and the original block on the bus.

// File: rtl/nes_pkg.sv
package nes_pkg;

    localparam int IO_W = 8;

    localparam logic [IO_W-1:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [IO_W-1:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [IO_W-1:0] CMD_READ_STAT   = 8'h70;

    localparam int STAT_READY_BIT = 6;
    localparam int STAT_FAIL_BIT  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADDR,
        ST_CONF,
        ST_WAIT_RB,
        ST_STAT_CMD,
        ST_STAT_RD
    } nes_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } nes_phase_e;

endpackage

// File: rtl/nes_strobe.sv
module nes_strobe
    import nes_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             go_i,
    input  logic [CNT_W-1:0] low_cyc_i,
    input  logic [CNT_W-1:0] high_cyc_i,
    output logic             active_o,
    output logic             strobe_n_o,
    output logic             sample_o,
    output logic             done_o
);

    nes_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - CNT_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (clr_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (go_i) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= span(low_cyc_i);
                    end
                end
                PH_LOW: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_HIGH;
                        cnt_q   <= span(high_cyc_i);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == '0) phase_q <= PH_IDLE;
                    else             cnt_q   <= cnt_q - CNT_W'(1);
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign active_o   = (phase_q != PH_IDLE);
    assign strobe_n_o = (phase_q != PH_LOW);
    assign sample_o   = (phase_q == PH_LOW)  && (cnt_q == '0);
    assign done_o     = (phase_q == PH_HIGH) && (cnt_q == '0);

endmodule

// File: rtl/nes_timeout.sv
module nes_timeout #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [TO_W-1:0] limit_i,
    output logic            expired_o
);

    logic [TO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!en_i)             cnt_q <= '0;
        else if (cnt_q != limit_i)  cnt_q <= cnt_q + TO_W'(1);
    end

    assign expired_o = en_i && (cnt_q == limit_i);

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nes_pkg::*;
#(
    parameter int BLK_W   = 10,
    parameter int PAGE_W  = 6,
    parameter int CNT_W   = 4,
    parameter int TO_W    = 16,
    parameter int TWB_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] blk_addr_i,
    input  logic             use_poll_i,
    input  logic [CNT_W-1:0] bus_low_cyc_i,
    input  logic [CNT_W-1:0] bus_high_cyc_i,
    input  logic [TO_W-1:0]  timeout_lim_i,
    output logic             nand_cle_o,
    output logic             nand_ale_o,
    output logic             nand_we_n_o,
    output logic             nand_re_n_o,
    output logic [IO_W-1:0]  nand_io_o,
    output logic             nand_io_oe_o,
    input  logic [IO_W-1:0]  nand_io_i,
    input  logic             nand_rb_n_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic             timeout_o
);

    localparam int ROW_W     = BLK_W + PAGE_W;
    localparam int ADDR_CYC  = (ROW_W + IO_W - 1) / IO_W;
    localparam int ROW_PAD_W = ADDR_CYC * IO_W;
    localparam int AC_W      = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1;
    localparam int GD_W      = $clog2(TWB_CYC + 1);

    nes_state_e         state_q, state_d;
    logic [ROW_PAD_W-1:0] row_q;
    logic [AC_W-1:0]    acyc_q;
    logic [GD_W-1:0]    guard_q;
    logic               poll_q;
    logic               rdy_seen_q;
    logic               stat_fail_q;
    logic               done_q, fail_q, tmo_q;

    logic st_go, st_active, st_strobe_n, st_sample, st_done;
    logic to_en, to_exp;
    logic finish_ok, abort;
    logic last_addr, guard_done;

    assign last_addr  = (acyc_q == AC_W'(ADDR_CYC - 1));
    assign guard_done = (guard_q == GD_W'(TWB_CYC));

    assign to_en = (state_q == ST_WAIT_RB) || (state_q == ST_STAT_CMD) ||
                   (state_q == ST_STAT_RD);

    assign st_go = !st_active &&
                   ((state_q == ST_SETUP) || (state_q == ST_ADDR) ||
                    (state_q == ST_CONF)  || (state_q == ST_STAT_CMD) ||
                    (state_q == ST_STAT_RD));

    nes_strobe #(.CNT_W(CNT_W)) strobe_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (abort),
        .go_i       (st_go),
        .low_cyc_i  (bus_low_cyc_i),
        .high_cyc_i (bus_high_cyc_i),
        .active_o   (st_active),
        .strobe_n_o (st_strobe_n),
        .sample_o   (st_sample),
        .done_o     (st_done)
    );

    nes_timeout #(.TO_W(TO_W)) timeout_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (to_en),
        .limit_i   (timeout_lim_i),
        .expired_o (to_exp)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        finish_ok = 1'b0;
        abort     = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_SETUP;
            ST_SETUP:    if (st_done) state_d = ST_ADDR;
            ST_ADDR:     if (st_done && last_addr) state_d = ST_CONF;
            ST_CONF:     if (st_done) state_d = poll_q ? ST_STAT_CMD : ST_WAIT_RB;
            ST_WAIT_RB:  if (guard_done && nand_rb_n_i) state_d = ST_STAT_CMD;
            ST_STAT_CMD: if (st_done) state_d = ST_STAT_RD;
            ST_STAT_RD: begin
                if (st_done && rdy_seen_q) begin
                    state_d   = ST_IDLE;
                    finish_ok = 1'b1;
                end
            end
            default:     state_d = ST_IDLE;
        endcase
        if (to_exp && !finish_ok) begin
            state_d = ST_IDLE;
            abort   = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q       <= '0;
            acyc_q      <= '0;
            guard_q     <= '0;
            poll_q      <= 1'b0;
            rdy_seen_q  <= 1'b0;
            stat_fail_q <= 1'b0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            tmo_q       <= 1'b0;
        end else begin
            done_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            if (state_q == ST_IDLE && start_i) begin
                row_q  <= ROW_PAD_W'({blk_addr_i, {PAGE_W{1'b0}}});
                poll_q <= use_poll_i;
                acyc_q <= '0;
                fail_q <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if (state_q == ST_ADDR && st_done && !last_addr)
                acyc_q <= acyc_q + AC_W'(1);
            if (state_q == ST_WAIT_RB) begin
                if (!guard_done) guard_q <= guard_q + GD_W'(1);
            end else begin
                guard_q <= '0;
            end
            if (state_q == ST_STAT_CMD) begin
                rdy_seen_q  <= 1'b0;
                stat_fail_q <= 1'b0;
            end else if (state_q == ST_STAT_RD && st_sample && !rdy_seen_q &&
                         nand_io_i[STAT_READY_BIT]) begin
                rdy_seen_q  <= 1'b1;
                stat_fail_q <= nand_io_i[STAT_FAIL_BIT];
            end
            if (finish_ok) fail_q <= stat_fail_q;
            if (abort) begin
                fail_q <= 1'b0;
                tmo_q  <= 1'b1;
            end
        end
    end

    // Pin outputs
    always_comb begin
        nand_cle_o   = 1'b0;
        nand_ale_o   = 1'b0;
        nand_we_n_o  = 1'b1;
        nand_re_n_o  = 1'b1;
        nand_io_o    = '0;
        nand_io_oe_o = 1'b0;
        unique case (state_q)
            ST_SETUP: begin
                nand_cle_o   = 1'b1;
                nand_io_o    = CMD_ERASE_SETUP;
                nand_io_oe_o = 1'b1;
                nand_we_n_o  = st_strobe_n;
            end
            ST_ADDR: begin
                nand_ale_o   = 1'b1;
                nand_io_o    = row_q[acyc_q*IO_W +: IO_W];
                nand_io_oe_o = 1'b1;
                nand_we_n_o  = st_strobe_n;
            end
            ST_CONF: begin
                nand_cle_o   = 1'b1;
                nand_io_o    = CMD_ERASE_GO;
                nand_io_oe_o = 1'b1;
                nand_we_n_o  = st_strobe_n;
            end
            ST_STAT_CMD: begin
                nand_cle_o   = 1'b1;
                nand_io_o    = CMD_READ_STAT;
                nand_io_oe_o = 1'b1;
                nand_we_n_o  = st_strobe_n;
            end
            ST_STAT_RD: nand_re_n_o = st_strobe_n;
            default: begin
                nand_cle_o = 1'b0;
            end
        endcase
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign fail_o    = fail_q;
    assign timeout_o = tmo_q;

endmodule

// File: rtl/nes_checker.sv
module nes_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] bus_low_cyc_i,
    input logic             nand_cle_o,
    input logic             nand_ale_o,
    input logic             nand_we_n_o,
    input logic             nand_re_n_o,
    input logic             nand_io_oe_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             fail_o,
    input logic             timeout_o
);

    logic [CNT_W:0] we_low_run;
    logic [CNT_W:0] exp_low;

    assign exp_low = (bus_low_cyc_i == '0) ? (CNT_W+1)'(1) : {1'b0, bus_low_cyc_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            we_low_run <= '0;
        else if (!nand_we_n_o) we_low_run <= we_low_run + (CNT_W+1)'(1);
        else                   we_low_run <= '0;
    end

    assert_cle_ale_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle_o && nand_ale_o));

    assert_we_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n_o) |-> (we_low_run == exp_low));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n_o && !nand_re_n_o));

    assert_read_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n_o |-> !nand_io_oe_o);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_tmo_nofail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && timeout_o) |-> !fail_o);

    assert_start_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

endmodule

bind nand_erase_seq nes_checker #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .bus_low_cyc_i (bus_low_cyc_i),
    .nand_cle_o    (nand_cle_o),
    .nand_ale_o    (nand_ale_o),
    .nand_we_n_o   (nand_we_n_o),
    .nand_re_n_o   (nand_re_n_o),
    .nand_io_oe_o  (nand_io_oe_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .fail_o        (fail_o),
    .timeout_o     (timeout_o)
);

// File: tb/nand_erase_seq_tb_top.sv
`timescale 1ns/1ps
module nand_erase_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [9:0]  blk_addr_i = '0;
    logic        use_poll_i = 1'b0;
    logic [3:0]  bus_low_cyc_i = 4'd1;
    logic [3:0]  bus_high_cyc_i = 4'd1;
    logic [15:0] timeout_lim_i = 16'd2000;
    logic        nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o, nand_io_oe_o;
    logic [7:0]  nand_io_o, nand_io_i;
    logic        nand_rb_n_i;
    logic        busy_o, done_o, fail_o, timeout_o;

    always #2.5 clk = ~clk;

    nand_erase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_addr_i(blk_addr_i),
        .use_poll_i(use_poll_i), .bus_low_cyc_i(bus_low_cyc_i),
        .bus_high_cyc_i(bus_high_cyc_i), .timeout_lim_i(timeout_lim_i),
        .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o), .nand_we_n_o(nand_we_n_o),
        .nand_re_n_o(nand_re_n_o), .nand_io_o(nand_io_o), .nand_io_oe_o(nand_io_oe_o),
        .nand_io_i(nand_io_i), .nand_rb_n_i(nand_rb_n_i), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .timeout_o(timeout_o)
    );

    // ---------------- flash model ----------------
    int          busy_len = 10;
    logic        m_fail = 1'b0;
    logic [8:0]  log_mem [2048];
    int          log_n = 0;
    int          cnt60 = 0, cnt70 = 0, conf_cnt = 0, busy70 = 0;
    logic        stat_mode = 1'b0;
    int          conf_seen = 0;
    int          busy_rem = 0;
    logic        rdy;

    assign rdy         = (busy_rem == 0) && (conf_seen == conf_cnt);
    assign nand_rb_n_i = rdy;
    assign nand_io_i   = stat_mode ? {1'b0, rdy, 5'b0, m_fail} : 8'h00;

    always @(posedge nand_we_n_o) begin
        if (rst_n) begin
            if (log_n < 2048) log_mem[log_n] = {nand_ale_o, nand_io_o};
            log_n = log_n + 1;
            if (nand_cle_o && nand_io_o == 8'h60) cnt60 = cnt60 + 1;
            if (nand_cle_o && nand_io_o == 8'hD0) conf_cnt = conf_cnt + 1;
            if (nand_cle_o && nand_io_o == 8'h70) begin
                cnt70 = cnt70 + 1;
                stat_mode = 1'b1;
                if (!rdy) busy70 = busy70 + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_rem  <= 0;
            conf_seen <= 0;
        end else if (conf_cnt != conf_seen) begin
            busy_rem  <= busy_len;
            conf_seen <= conf_cnt;
        end else if (busy_rem != 0) begin
            busy_rem <= busy_rem - 1;
        end
    end

    // ---------------- strobe width monitor ----------------
    int exp_low, exp_high;
    int wbad = 0, gbad = 0;
    always @(negedge clk) begin
        int lrun_s, hrun_s, gap_s, pidx_s;
        if (!nand_we_n_o) begin
            if (lrun_s == 0) gap_s = hrun_s;
            lrun_s = lrun_s + 1;
        end else begin
            if (lrun_s > 0) begin
                if (lrun_s != exp_low) wbad = wbad + 1;
                if (pidx_s >= 1 && pidx_s <= 3 && gap_s != exp_high + 1) gbad = gbad + 1;
                pidx_s = pidx_s + 1;
                lrun_s = 0;
                hrun_s = 1;
            end else begin
                hrun_s = hrun_s + 1;
            end
            if (!busy_o) pidx_s = 0;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic set_cfg(input int lo, input int hi);
        bus_low_cyc_i  = 4'(lo);
        bus_high_cyc_i = 4'(hi);
        exp_low  = (lo == 0) ? 1 : lo;
        exp_high = (hi == 0) ? 1 : hi;
    endtask

    task automatic check_seq(input int base, input int blk, input string tag);
        chk(log_mem[base]   == 9'h060, {tag, " R1 setup"}, int'(log_mem[base]), 'h060);
        chk(log_mem[base+1] == {1'b1, blk[1:0], 6'b0}, {tag, " R2 addr0"},
            int'(log_mem[base+1]), int'({1'b1, blk[1:0], 6'b0}));
        chk(log_mem[base+2] == {1'b1, blk[9:2]}, {tag, " R2 addr1"},
            int'(log_mem[base+2]), int'({1'b1, blk[9:2]}));
        chk(log_mem[base+3] == 9'h0D0, {tag, " R1 confirm"}, int'(log_mem[base+3]), 'h0D0);
    endtask

    task automatic do_erase(input int blk, input bit poll, input bit fl, input int blen,
                            input int lo, input int hi);
        int base, c60, c70, b70, wb, gb, cyc;
        @(negedge clk);
        set_cfg(lo, hi);
        blk_addr_i = 10'(blk); use_poll_i = poll; m_fail = fl; busy_len = blen;
        base = log_n; c60 = cnt60; c70 = cnt70; b70 = busy70; wb = wbad; gb = gbad;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(cyc);
        chk(done_o, "R7 done pulse", done_o, 1);
        chk(log_n - base == 5, "R6 write cycle count", log_n - base, 5);
        check_seq(base, blk, "sweep");
        chk(log_mem[base+4] == 9'h070, "R6 only status cmd", int'(log_mem[base+4]), 'h070);
        chk(cnt60 - c60 == 1, "R1 one setup", cnt60 - c60, 1);
        chk(cnt70 - c70 == 1, "R5 one status cmd", cnt70 - c70, 1);
        if (!poll) chk(busy70 == b70, "R4 status after ready", busy70 - b70, 0);
        chk(fail_o == fl && !timeout_o, "R7 result", {fail_o, timeout_o}, {fl, 1'b0});
        chk(wbad == wb, "R3 low width", wbad - wb, 0);
        chk(gbad == gb, "R3 strobe spacing", gbad - gb, 0);
        @(negedge clk);
        chk(!done_o, "R7 single pulse", done_o, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int cyc, base, c60;
        set_cfg(1, 1);
        repeat (4) @(negedge clk);
        chk(!nand_cle_o && !nand_ale_o && nand_we_n_o && nand_re_n_o && !busy_o && !done_o,
            "R10 reset state", {nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o, busy_o, done_o},
            'b001100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // sweep blocks, modes, timings, results
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 1024; b += 61)
                do_erase(b, p[0], b[0] ^ p[0], 5 + (b % 23), b % 4, b % 3);
            do_erase(1023, p[0], 1'b1, 30, 3, 2);
        end

        // R8: timeout in both modes
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            set_cfg(1, 1);
            use_poll_i = p[0]; busy_len = 400; m_fail = 1'b1; timeout_lim_i = 16'd40;
            blk_addr_i = 10'h155;
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
            wait_done(cyc);
            chk(done_o && timeout_o && !fail_o, "R8 timeout report",
                {done_o, timeout_o, fail_o}, 'b110);
            chk(cyc >= 40, "R8 limit respected", cyc, 40);
            chk(nand_we_n_o && nand_re_n_o, "R8 strobes idle",
                {nand_we_n_o, nand_re_n_o}, 'b11);
            repeat (450) @(negedge clk);
        end
        timeout_lim_i = 16'd2000;

        // R6: start during busy ignored
        @(negedge clk);
        set_cfg(2, 1);
        use_poll_i = 1'b0; busy_len = 120; m_fail = 1'b0; blk_addr_i = 10'h2A7;
        base = log_n; c60 = cnt60;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (60) @(negedge clk);
        blk_addr_i = 10'h0F0; start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        wait_done(cyc);
        chk(cnt60 - c60 == 1, "R6 start ignored while busy", cnt60 - c60, 1);
        check_seq(base, 'h2A7, "ignore");
        repeat (3) @(negedge clk);
        chk(!busy_o, "R6 no second erase", busy_o, 0);

        // R9: start held through completion
        @(negedge clk);
        use_poll_i = 1'b1; busy_len = 25; m_fail = 1'b1; blk_addr_i = 10'h0C3;
        base = log_n;
        start_i = 1'b1;
        repeat (20) @(negedge clk);
        blk_addr_i = 10'h3A5; m_fail = 1'b0;
        wait_done(cyc);
        chk(done_o && fail_o == 1'b0, "R9 first result at pulse", {done_o, fail_o}, 'b10);
        check_seq(base, 'h0C3, "b2b first");
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R9 new erase accepted", busy_o, 1);
        base = log_n;
        wait_done(cyc);
        chk(done_o && !fail_o && !timeout_o, "R9 second result",
            {done_o, fail_o, timeout_o}, 'b100);
        check_seq(base, 'h3A5, "b2b second R9");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule